// File: doc/BRIEF.md
# USB Link Inter-Packet Turnaround Timer

This block sits beside the data path of a USB link controller that talks to an 8-bit low-pin-count transceiver. It watches a small set of interface event strobes: the link starting a transmit command, the stop strobe that closes a high-speed transmit, the direction line falling, a decoded receive status that shows the receiver going inactive, a decoded line-state change from SE0 to J, and the start of an incoming packet. From these strobes it tells the link when it may drive the command byte for its next packet.

After a packet ends, the block counts a turnaround window. Its length and the event that starts it depend on the bus speed and on whether the last packet was sent or received. The link may transmit once the lower bound of the window has been reached. If no transmit command has come by the upper bound, a late-gap flag is raised. After every transmit, a response timer runs in parallel. It produces a one-cycle time-out pulse unless a response or a new transmit cancels it first.

Speed and role are static inputs. If either one changes, the block drops whatever it was counting and returns to idle.

Top module: `ipg_turnaround`

## Requirements
- R1: Out of reset, tx_allowed_o is 1, timeout_o is 0 and gap_late_o is 0.
- R2: At high speed (speed_i = 2'b00) in the host role (is_host_i = 1), a transmit that begins with txcmd_i and ends with stp_i starts a window. If stp_i is sampled at edge k, tx_allowed_o is 0 after edges k+1 through k+14 and 1 after edge k+15. gap_late_o stays 0 through edge k+24 and becomes 1 after edge k+25 if no txcmd_i has come.
- R3: At high speed, a received packet ends on dir_fall_i or on rx_act_low_i, whichever comes first. If that end is sampled at edge k, tx_allowed_o is 1 after edge k+1. gap_late_o is 0 through edge k+14 and becomes 1 after edge k+15. This holds in both roles.
- R4: At full speed (2'b01) and low speed (2'b10 or 2'b11), both sent and received packets end only on se0_to_j_i. The window is 7 to 18 clocks at full speed and 77 to 247 clocks at low speed, for both sequence types, and is timed as in R2.
- R5: In the peripheral role, ending a transmit starts no turnaround window. tx_allowed_o stays 0 until the response timer expires.
- R6: The end of every transmit starts a response timer. If the end is sampled at edge k, timeout_o is 1 for exactly the one cycle after edge k+L, where L is 92 at high speed, 80 at full speed and 718 at low speed.
- R7: An accepted rx_start_i or txcmd_i that comes before the expiry cancels the response timer, and then no timeout_o pulse follows.
- R8: tx_allowed_o is 0 while a transmit or a receive is in progress. rx_start_i is accepted whenever no transmit is in progress, including the very clock after a receive has ended.
- R9: gap_late_o stays high until an accepted txcmd_i, an accepted rx_start_i or a change of speed or role.
- R10: A change of speed_i or is_host_i at a clock edge returns the block to idle at that edge. After that edge tx_allowed_o is 1 and gap_late_o and timeout_o are 0, and no earlier count goes on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| speed_i | input | 2 | 00 high, 01 full, 10/11 low speed |
| is_host_i | input | 1 | 1 = host role, 0 = peripheral role |
| txcmd_i | input | 1 | Link drives a transmit command this cycle |
| stp_i | input | 1 | Stop strobe closing a high-speed transmit |
| dir_fall_i | input | 1 | Direction line deasserted |
| rx_act_low_i | input | 1 | Receive status shows the receiver inactive |
| se0_to_j_i | input | 1 | Receive status shows line state changed from SE0 to J |
| rx_start_i | input | 1 | Direction asserted with the receiver active |
| tx_allowed_o | output | 1 | Link may drive the next transmit command |
| timeout_o | output | 1 | One-cycle pulse: no response after a transmit |
| gap_late_o | output | 1 | Turnaround window passed without a transmit |

## Verification
A phase register stuck in transmit or receive shows at once as tx_allowed_o held low. A window counter that is off by one moves the rising edge of tx_allowed_o or gap_late_o by one cycle, and the bench sees this on the first window it times at that speed. A wrong bound or a wrong start-event choice shows up within one window length: 24 clocks at high speed and 247 at low speed. A response timer that is not cleared shows as a stray timeout_o pulse up to 718 clocks after the cancelling event.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
  typedef enum logic [1:0] {
    SPD_HS = 2'b00,
    SPD_FS = 2'b01,
    SPD_LS = 2'b10
  } speed_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_TX   = 2'b01,
    PH_RX   = 2'b10
  } phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ipg_gap_win.sv
module ipg_gap_win #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [CW-1:0] lo_i,
  input  logic [CW-1:0] hi_i,
  output logic          busy_o,
  output logic          late_o
);
  logic          run_q;
  logic          late_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lo_q;
  logic [CW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      late_q <= 1'b0;
      cnt_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (stop_i) begin
      run_q  <= 1'b0;
      late_q <= 1'b0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      late_q <= 1'b0;
      cnt_q  <= '0;
      lo_q   <= lo_i;
      hi_q   <= hi_i;
    end else if (run_q) begin
      if (cnt_q == hi_q) begin
        run_q  <= 1'b0;
        late_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = run_q && (cnt_q < lo_q);
  assign late_o = late_q;

  // R2
  win_stays_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);
endmodule

// File: rtl/ipg_rsp_tmr.sv
module ipg_rsp_tmr #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [CW-1:0] lim_i,
  output logic          run_o,
  output logic          expire_o
);
  logic          run_q;
  logic          exp_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      exp_q <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
    end else if (stop_i) begin
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else if (start_i) begin
      run_q <= 1'b1;
      exp_q <= 1'b0;
      cnt_q <= '0;
      lim_q <= lim_i;
    end else begin
      exp_q <= 1'b0;
      if (run_q) begin
        if (cnt_q == lim_q - 1'b1) begin
          run_q <= 1'b0;
          exp_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign run_o    = run_q;
  assign expire_o = exp_q;

  // R6
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
  // R6
  expire_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(expire_o) |-> $past(run_q));
endmodule

// File: rtl/ipg_turnaround.sv
module ipg_turnaround #(
  parameter int HS_TT_LO = 15,
  parameter int HS_TT_HI = 24,
  parameter int HS_RT_LO = 1,
  parameter int HS_RT_HI = 14,
  parameter int FS_LO    = 7,
  parameter int FS_HI    = 18,
  parameter int LS_LO    = 77,
  parameter int LS_HI    = 247,
  parameter int HS_RSP   = 92,
  parameter int FS_RSP   = 80,
  parameter int LS_RSP   = 718
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] speed_i,
  input  logic       is_host_i,
  input  logic       txcmd_i,
  input  logic       stp_i,
  input  logic       dir_fall_i,
  input  logic       rx_act_low_i,
  input  logic       se0_to_j_i,
  input  logic       rx_start_i,
  output logic       tx_allowed_o,
  output logic       timeout_o,
  output logic       gap_late_o
);
  import ipg_pkg::*;

  localparam int MAXV = max2(max2(max2(HS_TT_HI, HS_RT_HI), max2(FS_HI, LS_HI)),
                             max2(HS_RSP, max2(FS_RSP, LS_RSP)));
  localparam int CW = $clog2(MAXV + 1);

  phase_e        phase_q, phase_d;
  logic [2:0]    cfg_q;
  logic          cfg_chg, hs;
  logic          tx_end, rx_end, txcmd_acc, rx_start_acc;
  logic          win_start, win_stop, win_busy, win_late;
  logic          rsp_run, rsp_exp;
  logic [CW-1:0] win_lo, win_hi, rsp_lim;

  assign cfg_chg      = {speed_i, is_host_i} != cfg_q;
  assign hs           = speed_i == SPD_HS;
  assign tx_end       = (phase_q == PH_TX) && (hs ? stp_i : se0_to_j_i);
  assign rx_end       = (phase_q == PH_RX) && (hs ? (dir_fall_i || rx_act_low_i) : se0_to_j_i);
  assign txcmd_acc    = txcmd_i && (phase_q == PH_IDLE);
  assign rx_start_acc = rx_start_i && (phase_q != PH_TX);

  always_comb begin
    phase_d = phase_q;
    if (cfg_chg)            phase_d = PH_IDLE;
    else if (rx_start_acc)  phase_d = PH_RX;
    else if (txcmd_acc)     phase_d = PH_TX;
    else if (tx_end || rx_end) phase_d = PH_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cfg_q   <= {SPD_HS, 1'b0};
    end else begin
      phase_q <= phase_d;
      cfg_q   <= {speed_i, is_host_i};
    end
  end

  // window bounds and response limit per speed and sequence type
  always_comb begin
    case (speed_i)
      SPD_HS: begin
        win_lo  = tx_end ? CW'(HS_TT_LO) : CW'(HS_RT_LO);
        win_hi  = tx_end ? CW'(HS_TT_HI) : CW'(HS_RT_HI);
        rsp_lim = CW'(HS_RSP);
      end
      SPD_FS: begin
        win_lo  = CW'(FS_LO);
        win_hi  = CW'(FS_HI);
        rsp_lim = CW'(FS_RSP);
      end
      default: begin
        win_lo  = CW'(LS_LO);
        win_hi  = CW'(LS_HI);
        rsp_lim = CW'(LS_RSP);
      end
    endcase
  end

  // transmit-to-transmit windows exist only for a host
  assign win_start = (tx_end && is_host_i) || rx_end;
  assign win_stop  = cfg_chg || txcmd_acc || rx_start_acc;

  ipg_gap_win #(.CW(CW)) i_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (win_start),
    .stop_i  (win_stop),
    .lo_i    (win_lo),
    .hi_i    (win_hi),
    .busy_o  (win_busy),
    .late_o  (win_late)
  );

  ipg_rsp_tmr #(.CW(CW)) i_rsp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tx_end),
    .stop_i   (win_stop),
    .lim_i    (rsp_lim),
    .run_o    (rsp_run),
    .expire_o (rsp_exp)
  );

  assign tx_allowed_o = (phase_q == PH_IDLE) && !win_busy && !(rsp_run && !is_host_i);
  assign timeout_o    = rsp_exp;
  assign gap_late_o   = win_late;

  // R10
  cfg_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_chg |=> (tx_allowed_o && !gap_late_o && !timeout_o));
  // R3
  late_implies_allowed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_late_o |-> tx_allowed_o);
  // R8
  rx_blocks_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_start_acc && !cfg_chg) |=> !tx_allowed_o);
  // R5
  timeout_frees_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> tx_allowed_o);
endmodule

// File: tb/test_ipg_turnaround.sv
`timescale 1ns/1ps
module test_ipg_turnaround;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] speed = 2'b00;
  logic       host = 1'b1;
  logic       txcmd = 1'b0, stp = 1'b0, dir_fall = 1'b0, rx_low = 1'b0;
  logic       se0j = 1'b0, rx_start = 1'b0;
  logic       allowed, tmo, late;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  ipg_turnaround i_ipg_turnaround (
    .clk_i(clk), .rst_ni(rst_n), .speed_i(speed), .is_host_i(host),
    .txcmd_i(txcmd), .stp_i(stp), .dir_fall_i(dir_fall), .rx_act_low_i(rx_low),
    .se0_to_j_i(se0j), .rx_start_i(rx_start),
    .tx_allowed_o(allowed), .timeout_o(tmo), .gap_late_o(late));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int lo_of(input int spd, input bit tt);
    if (spd == 0) return tt ? 15 : 1;
    return (spd == 1) ? 7 : 77;
  endfunction
  function automatic int hi_of(input int spd, input bit tt);
    if (spd == 0) return tt ? 24 : 14;
    return (spd == 1) ? 18 : 247;
  endfunction
  function automatic int lim_of(input int spd);
    return (spd == 0) ? 92 : (spd == 1) ? 80 : 718;
  endfunction

  // 0 txcmd, 1 stp, 2 dir_fall, 3 rx_low, 4 se0j, 5 rx_start
  task automatic pulse(input int ev);
    @(negedge clk);
    case (ev)
      0: txcmd = 1'b1;
      1: stp = 1'b1;
      2: dir_fall = 1'b1;
      3: rx_low = 1'b1;
      4: se0j = 1'b1;
      default: rx_start = 1'b1;
    endcase
    @(negedge clk);
    {txcmd, stp, dir_fall, rx_low, se0j, rx_start} = '0;
  endtask

  task automatic restart(input int spd, input bit h);
    @(negedge clk);
    speed = (spd == 0) ? 2'd1 : 2'd0;
    host = h;
    @(negedge clk);
    speed = 2'(spd);
    @(negedge clk);
  endtask

  task automatic tx_seq(input int spd, input bit h);
    int lo, hi, lim;
    lo = lo_of(spd, 1'b1); hi = hi_of(spd, 1'b1); lim = lim_of(spd);
    restart(spd, h);
    pulse(0);
    chk(allowed == 1'b0, "R8 tx in progress", allowed, 0);
    pulse((spd == 0) ? 1 : 4);
    for (int j = 1; j <= lim + 1; j++) begin
      @(negedge clk);
      if (h) begin
        chk(allowed == (j >= lo), (spd == 0) ? "R2 tt allowed" : "R4 tt allowed", allowed, int'(j >= lo));
        chk(late == (j > hi), (spd == 0) ? "R2 tt late" : "R4 tt late", late, int'(j > hi));
      end else begin
        chk(allowed == (j >= lim), "R5 peripheral after tx", allowed, int'(j >= lim));
        chk(late == 1'b0, "R5 no window", late, 0);
      end
      chk(tmo == (j == lim), "R6 timeout", tmo, int'(j == lim));
    end
    if (h) begin
      pulse(0);
      chk(late == 1'b0, "R9 late cleared by txcmd", late, 0);
    end
  endtask

  task automatic rx_seq(input int spd, input bit h, input bit alt_end);
    int lo, hi;
    lo = lo_of(spd, 1'b0); hi = hi_of(spd, 1'b0);
    restart(spd, h);
    pulse(5);
    chk(allowed == 1'b0, "R8 rx in progress", allowed, 0);
    pulse((spd != 0) ? 4 : (alt_end ? 3 : 2));
    for (int j = 1; j <= hi + 1; j++) begin
      @(negedge clk);
      chk(allowed == (j >= lo), (spd == 0) ? "R3 rt allowed" : "R4 rt allowed", allowed, int'(j >= lo));
      chk(late == (j > hi), (spd == 0) ? "R3 rt late" : "R4 rt late", late, int'(j > hi));
      chk(tmo == 1'b0, "R6 no timeout after rx", tmo, 0);
    end
    pulse(5);
    chk(late == 1'b0, "R9 late cleared by rx_start", late, 0);
    chk(allowed == 1'b0, "R8 rx again", allowed, 0);
  endtask

  initial begin
    #1;
    chk(allowed == 1'b1, "R1 allowed in reset", allowed, 1);
    chk(tmo == 1'b0, "R1 timeout in reset", tmo, 0);
    chk(late == 1'b0, "R1 late in reset", late, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(allowed == 1'b1 && tmo == 1'b0 && late == 1'b0, "R1 after reset",
        {allowed, tmo, late}, 3'b100);

    for (int s = 0; s < 3; s++)
      for (int h = 0; h < 2; h++) begin
        tx_seq(s, h[0]);
        rx_seq(s, h[0], 1'b0);
        if (s == 0) rx_seq(s, h[0], 1'b1);
      end

    // R7 cancel by rx_start
    restart(0, 1'b0);
    pulse(0); pulse(1);
    repeat (10) @(negedge clk);
    pulse(5);
    for (int j = 0; j < 100; j++) begin
      @(negedge clk);
      chk(tmo == 1'b0, "R7 cancel by rx_start", tmo, 0);
    end
    // R7 cancel by txcmd
    restart(0, 1'b1);
    pulse(0); pulse(1);
    repeat (20) @(negedge clk);
    pulse(0);
    for (int j = 0; j < 100; j++) begin
      @(negedge clk);
      chk(tmo == 1'b0, "R7 cancel by txcmd", tmo, 0);
    end

    // R8 back-to-back receive, one clock apart
    restart(0, 1'b0);
    pulse(5);
    @(negedge clk); dir_fall = 1'b1;
    @(negedge clk); dir_fall = 1'b0; rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
    chk(allowed == 1'b0, "R8 second rx accepted", allowed, 0);
    repeat (5) @(negedge clk);
    chk(allowed == 1'b0, "R8 still receiving", allowed, 0);
    pulse(3);
    chk(allowed == 1'b0, "R3 edge k", allowed, 0);
    @(negedge clk);
    chk(allowed == 1'b1, "R3 after second rx", allowed, 1);

    // R10 restart mid-count
    restart(0, 1'b1);
    pulse(0); pulse(1);
    repeat (5) @(negedge clk);
    chk(allowed == 1'b0, "R10 counting", allowed, 0);
    speed = 2'd1;
    @(negedge clk);
    chk(allowed == 1'b1 && late == 1'b0 && tmo == 1'b0, "R10 idle after change",
        {allowed, late, tmo}, 3'b100);
    for (int j = 0; j < 120; j++) begin
      @(negedge clk);
      chk(tmo == 1'b0 && late == 1'b0 && allowed == 1'b1, "R10 no stale count",
          {allowed, late, tmo}, 3'b100);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule